// File: doc/BRIEF.md
# Indirect Configuration-Space Access Bridge

This block lets software reach a 4 KB byte-addressable configuration space that is not directly mapped. It does so through three 32-bit host registers: one for write data, one for read data and one for command and flags. Software first loads the dword address and the byte-lane mask into the command register. It then sets the write-start or the read-start flag with a byte write to byte 2 of that register. The bridge runs a single transfer on an internal request/acknowledge port and captures any read result. When the transfer completes, the bridge clears the flag.

Software polls byte 2 of the command register until it reads zero. For a read, software then takes the whole dword from the read-data register and selects the byte it needs using the low two bits of its own address. Only one transfer can be outstanding at a time. A fixed, parameterised number of idle cycles comes between the start flag and the internal request. Software gives up after roughly 200 µs of polling, so every transfer must finish well inside that window.

Top module: `cfg_bridge`

## Requirements
- R1: After reset, all three host registers read zero and the internal request is low.
- R2: The write-data register sits at host byte offset 0x3E8. Each of its four byte lanes is written only when the matching host byte-enable bit is set.
- R3: The command register sits at offset 0x3F0.
  - Bits 11:2 hold the dword address.
  - Bits 15:12 hold the byte-lane mask, where bit 12+n selects lane n.
  - Bits 17 and 16 are the flags.
  - Bits 1:0 and 31:18 always read zero.
- R4: Writing 1 to bit 16 (write flag) starts a write.
  - The internal request rises DLY+1 cycles after the host write edge.
  - The internal write strobe is 1.
  - The internal address is {bits 11:2, 2'b00}.
  - The internal byte enables equal bits 15:12.
  - The internal data equals the write-data register.
- R5: Writing 1 to bit 17 (read flag) starts a read. The read uses the same address rule, with the write strobe at 0 and all four byte enables at 1.
- R6: A started flag reads 1 until the edge at which the acknowledge is sampled with the request high. At that edge the flag returns to 0.
- R7: A read result is captured into the read-data register at offset 0x3EC when the transfer completes. Host writes to 0x3EC have no effect.
- R8: From the rise of the request until the acknowledge, the request, address, byte enables, write strobe and write data stay constant.
- R9: While a transfer is in progress, the following host writes are ignored:
  - new start flags;
  - writes to the write-data register;
  - writes to the command register.
- R10: If both flags are written to 1 in the same host write, only a write is performed, and the read flag reads 0.
- R11: With an internal port that acknowledges L cycles after it sees the request, the flag clears exactly DLY+L+3 cycles after the start write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access valid |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 12 | Host byte offset |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational on h_addr |
| c_req | output | 1 | Internal transfer request |
| c_we | output | 1 | Internal write strobe |
| c_addr | output | 12 | Internal dword-aligned byte address |
| c_be | output | 4 | Internal byte enables |
| c_wdata | output | 32 | Internal write data |
| c_ack | input | 1 | Internal transfer acknowledge |
| c_rdata | input | 32 | Internal read data, valid with c_ack |

## Verification
Two events can land on the same clock edge:
- a host write that sets a start flag or touches the data and command registers;
- the transfer that is still in flight.

The bench provokes this collision in two ways:
- With a long internal latency, it issues fresh flags and register writes while the request is held.
- It writes both flags in one host write.

The scoreboard judges the outcome. It must see exactly one internal transfer, with the original address, lanes and data, and the register readback after completion must show the original contents.

// File: rtl/cfg_bridge.sv
module cfg_bridge #(
  parameter int          DLY     = 2,
  parameter logic [11:0] WD_OFS  = 12'h3E8,
  parameter logic [11:0] RD_OFS  = 12'h3EC,
  parameter logic [11:0] CMD_OFS = 12'h3F0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_sel,
  input  logic        h_we,
  input  logic [11:0] h_addr,
  input  logic [3:0]  h_be,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  output logic        c_req,
  output logic        c_we,
  output logic [11:0] c_addr,
  output logic [3:0]  c_be,
  output logic [31:0] c_wdata,
  input  logic        c_ack,
  input  logic [31:0] c_rdata
);
  localparam int CW = $clog2(DLY + 2);

  logic [31:0]   wd_q, rd_q;
  logic [9:0]    adr_q;
  logic [3:0]    ben_q;
  logic          bw_q, br_q, req_q;
  logic [CW-1:0] cnt_q;

  wire busy    = bw_q | br_q;
  wire hw      = h_sel & h_we & ~busy;
  wire sel_wd  = h_addr[11:2] == WD_OFS[11:2];
  wire sel_rd  = h_addr[11:2] == RD_OFS[11:2];
  wire sel_cmd = h_addr[11:2] == CMD_OFS[11:2];
  wire flag_wr = hw & sel_cmd & h_be[2];
  wire go_w    = flag_wr & h_wdata[16];
  wire go_r    = flag_wr & h_wdata[17] & ~h_wdata[16];
  wire done    = req_q & c_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_q  <= '0;
      rd_q  <= '0;
      adr_q <= '0;
      ben_q <= '0;
      bw_q  <= 1'b0;
      br_q  <= 1'b0;
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (hw && sel_wd)
        for (int i = 0; i < 4; i++)
          if (h_be[i]) wd_q[8*i +: 8] <= h_wdata[8*i +: 8];
      if (hw && sel_cmd) begin
        if (h_be[0]) adr_q[5:0] <= h_wdata[7:2];
        if (h_be[1]) begin
          adr_q[9:6] <= h_wdata[11:8];
          ben_q      <= h_wdata[15:12];
        end
      end
      if (go_w || go_r) begin
        bw_q  <= go_w;
        br_q  <= go_r;
        cnt_q <= CW'(DLY);
      end else if (busy && !req_q) begin
        if (cnt_q == '0) req_q <= 1'b1;
        else             cnt_q <= cnt_q - 1'b1;
      end else if (done) begin
        req_q <= 1'b0;
        bw_q  <= 1'b0;
        br_q  <= 1'b0;
        if (br_q) rd_q <= c_rdata;
      end
    end
  end

  assign c_req   = req_q;
  assign c_we    = bw_q;
  assign c_addr  = {adr_q, 2'b00};
  assign c_be    = bw_q ? ben_q : 4'hF;
  assign c_wdata = wd_q;

  always_comb begin
    h_rdata = '0;
    if (sel_wd)       h_rdata = wd_q;
    else if (sel_rd)  h_rdata = rd_q;
    else if (sel_cmd) h_rdata = {14'd0, br_q, bw_q, ben_q, adr_q, 2'b00};
  end
endmodule

// File: rtl/cfg_bridge_chk.sv
module cfg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        c_req,
  input logic        c_ack,
  input logic        c_we,
  input logic [11:0] c_addr,
  input logic [3:0]  c_be,
  input logic [31:0] c_wdata,
  input logic [31:0] c_rdata,
  input logic        bw,
  input logic        br,
  input logic [31:0] rd
);
  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    c_req && !c_ack |=> c_req && $stable(c_addr) && $stable(c_be) && $stable(c_we) && $stable(c_wdata));

  a_r6_req_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
    c_req |-> (bw || br));

  a_r10_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bw, br}));

  a_r6_clear_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    c_req && c_ack |=> !bw && !br && !c_req);

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    c_req && c_ack && !c_we |=> rd == $past(c_rdata));

  a_r5_read_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    c_req && !c_we |-> c_be == 4'hF);
endmodule

bind cfg_bridge cfg_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .c_req(c_req), .c_ack(c_ack), .c_we(c_we),
  .c_addr(c_addr), .c_be(c_be), .c_wdata(c_wdata), .c_rdata(c_rdata),
  .bw(bw_q), .br(br_q), .rd(rd_q)
);

// File: tb/cfg_bridge_tb.sv
module cfg_bridge_tb;
  localparam int DLY = 2;
  logic clk = 0, rst_n = 0;
  logic h_sel = 0, h_we = 0;
  logic [11:0] h_addr = 0;
  logic [3:0]  h_be = 0;
  logic [31:0] h_wdata = 0, h_rdata;
  logic c_req, c_we, c_ack = 0;
  logic [11:0] c_addr;
  logic [3:0]  c_be;
  logic [31:0] c_wdata, c_rdata = 0;

  int n_chk = 0, n_fail = 0, lat = 0, mcnt = 0;
  logic [31:0] mem [1024];
  logic [31:0] shadow [1024];
  logic [48:0] exp_q [$];
  logic [31:0] m_wd = 0;
  logic [9:0]  m_adr = 0;
  logic [3:0]  m_be = 0;

  always #5 clk = ~clk;

  cfg_bridge #(.DLY(DLY)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // internal memory model with programmable latency
  always @(posedge clk) begin
    if (c_ack) begin
      c_ack <= 0; mcnt <= 0;
    end else if (c_req) begin
      if (mcnt >= lat) begin
        c_ack   <= 1;
        c_rdata <= mem[c_addr[11:2]];
        if (c_we)
          for (int i = 0; i < 4; i++)
            if (c_be[i]) mem[c_addr[11:2]][8*i +: 8] <= c_wdata[8*i +: 8];
      end else mcnt <= mcnt + 1;
    end
  end

  // scoreboard monitor: stability while pending (R8), compare at ack
  always @(negedge clk) begin
    if (c_req) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R9 unexpected transfer actual=%h expected=none", {c_we, c_addr, c_be});
      end else begin
        chk("R8 we/addr/be", {15'd0, c_we, c_addr, c_be}, {15'd0, exp_q[0][48:32]});
        if (c_we) chk("R8 wdata", c_wdata, exp_q[0][31:0]);
        if (c_ack) void'(exp_q.pop_front());
      end
    end
  end

  task automatic hwr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    h_sel = 1; h_we = 1; h_addr = a; h_be = be; h_wdata = d;
    @(posedge clk); @(negedge clk);
    h_sel = 0; h_we = 0;
  endtask

  task automatic hrd(input logic [11:0] a, output logic [31:0] d);
    h_addr = a; #1 d = h_rdata;
  endtask

  task automatic set_wd(input logic [3:0] be, input logic [31:0] d);
    hwr(12'h3E8, be, d);
    for (int i = 0; i < 4; i++) if (be[i]) m_wd[8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic set_cmd(input logic [11:0] a, input logic [3:0] be);
    hwr(12'h3F0, 4'b0011, {16'd0, be, a});
    m_adr = a[11:2]; m_be = be;
  endtask

  task automatic go(input logic [1:0] flags);
    logic we;
    we = flags[0];
    if (we) begin
      exp_q.push_back({1'b1, m_adr, 2'b00, m_be, m_wd});
      for (int i = 0; i < 4; i++) if (m_be[i]) shadow[m_adr][8*i +: 8] = m_wd[8*i +: 8];
    end else exp_q.push_back({1'b0, m_adr, 2'b00, 4'hF, 32'd0});
    hwr(12'h3F0, 4'b0100, {14'd0, flags, 16'd0});
  endtask

  task automatic wait_done(input bit timed);
    int kreq, k;
    logic [31:0] v;
    kreq = -1;
    k = 0;
    for (int n = 0; n < 400; n++) begin
      hrd(12'h3F0, v);
      if (kreq < 0 && c_req) kreq = k;
      if (v[17:16] == 0) break;
      if (k == 0) chk("R6 flag busy", {31'd0, |v[17:16]}, 32'd1);
      @(negedge clk); k++;
    end
    if (timed) begin
      chk("R4 req delay", kreq, DLY + 1);
      chk("R11 completion cycles", k, DLY + lat + 3);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) begin mem[i] = 0; shadow[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    hrd(12'h3E8, v); chk("R1 wdata reset", v, 0);
    hrd(12'h3EC, v); chk("R1 rdata reset", v, 0);
    hrd(12'h3F0, v); chk("R1 cmd reset", v, 0);
    chk("R1 req reset", {31'd0, c_req}, 0);
    // R2 lanes
    set_wd(4'b0101, 32'h1122_3344);
    hrd(12'h3E8, v); chk("R2 lanes 0,2", v, 32'h0022_0044);
    set_wd(4'b1010, 32'hAABB_CCDD);
    hrd(12'h3E8, v); chk("R2 lanes 1,3", v, 32'hAA22_CC44);
    // R3 field layout
    hwr(12'h3F0, 4'b1011, 32'hFFFF_FFFF);
    hrd(12'h3F0, v); chk("R3 cmd fields", v, 32'h0000_FFFC);
    // R4 write, latency 0
    lat = 0;
    set_wd(4'hF, 32'hA1B2_C3D4);
    set_cmd(12'h010, 4'b0100);
    go(2'b01); wait_done(1);
    // R5/R7 read back
    set_cmd(12'h010, 4'b0000);
    go(2'b10); wait_done(1);
    hrd(12'h3EC, v); chk("R7 read data", v, shadow[4]);
    chk("R5 byte at addr&3", {24'd0, v[8*2 +: 8]}, 32'h0000_00B2);
    hwr(12'h3EC, 4'hF, 32'hDEAD_BEEF);
    hrd(12'h3EC, v); chk("R7 rdata write ignored", v, shadow[4]);
    // several latencies and lanes
    for (int t = 0; t < 4; t++) begin
      lat = t * 3;
      set_wd(4'hF, 32'h0101_0101 * (t + 5));
      set_cmd(12'h200 + 12'(t * 4), 4'b0001 << t);
      go(2'b01); wait_done(1);
      go(2'b10); wait_done(1);
      hrd(12'h3EC, v); chk("R7 lane read", v, shadow[m_adr]);
    end
    // R9 busy: flags and register writes ignored
    lat = 10;
    set_wd(4'hF, 32'h5555_AAAA);
    set_cmd(12'h0F0, 4'b1000);
    go(2'b01);
    hwr(12'h3F0, 4'b0111, 32'h0002_F3FC);
    hwr(12'h3E8, 4'hF, 32'h1234_5678);
    wait_done(0);
    hrd(12'h3E8, v); chk("R9 wdata kept", v, m_wd);
    hrd(12'h3F0, v); chk("R9 cmd kept", v, {16'd0, m_be, m_adr, 2'b00});
    @(negedge clk);
    chk("R9 queue drained", exp_q.size(), 0);
    // R10 both flags: write wins
    lat = 2;
    set_wd(4'hF, 32'hCAFE_0001);
    set_cmd(12'h3FC, 4'b0010);
    go(2'b11);
    hrd(12'h3F0, v); chk("R10 flags", {30'd0, v[17:16]}, 32'd1);
    wait_done(1);
    go(2'b10); wait_done(1);
    hrd(12'h3EC, v); chk("R10 write landed", v, shadow[m_adr]);
    repeat (3) @(negedge clk);
    chk("scoreboard empty", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule